// File: doc/BRIEF.md
# Fail-first vector compare sequencer

This block walks a short vector of signed elements in ascending index order, one element per clock. Each element is compared against a scalar that is captured at start, and a 4-bit condition field holding the result is written back for that element. After each compare, one bit of the fresh field is tested, optionally inverted. When early termination is armed and the test succeeds, the loop stops at that element and the vector length is cut short.

The cut is either inclusive or exclusive. In inclusive mode the succeeding element keeps its new field, and the length becomes the step index plus one. In exclusive mode the length becomes the step index, and the element's field is written back with the value it held before the step. That old value is read through a read port that shares the write index.

A wide-field flag marks the case where the destination condition operand names a single bit rather than a whole field. In that case the tested bit is forced to the equal position. The element source and the condition storage sit outside the block and are reached through combinational read ports.

Top module: `vcmp_ff_seq`

## Requirements
- R1: The field written for element e against scalar s (both signed, two's complement) is 4'b1000 when e<s, 4'b0100 when e>s and 4'b0010 when e==s. Bit 0 is always written as 0.
- R2: After a start accepted at one rising edge, element index 0 is read and its field written in the following cycle. Each later cycle handles the next index, one write per cycle, with `cf_idx` equal to `elem_idx`.
- R3: Unless both `rec_en` and `ffirst_en` were high at start, every element from 0 to `vlen`-1 is written, and `vl_out` becomes `vlen`.
- R4: The selector `bit_sel` picks field bit 3-`bit_sel`: value 0 tests 4'b1000, 1 tests 4'b0100, 2 tests 4'b0010 and 3 tests bit 0. With `inv` set, the test succeeds when that bit is 0; otherwise it succeeds when the bit is 1.
- R5: With `wide_sel` set, the tested bit is the equal bit (selector value 2), whatever `bit_sel` holds.
- R6: With `incl` set, the first succeeding step s writes its new field normally, ends the loop, and sets `vl_out` to s+1. This includes a hit on the last element.
- R7: With `incl` clear, the first succeeding step s writes `cf_rdata`, the field's prior value, instead of the new field. It ends the loop and sets `vl_out` to s, which is 0 for a hit on the first element.
- R8: A start with `vlen` equal to 0 makes no writes and raises `done` in the cycle after the start edge, with `vl_out` equal to 0.
- R9: `done` is high for exactly one cycle, in the cycle after the last write. `vl_out` changes only then and holds afterwards. A start pulse while a loop is running is ignored.
- R10: During and right after reset, `done` is 0, `vl_out` is 0 and `cf_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| vlen | input | LW | Vector length captured at start |
| scalar | input | DW | Signed scalar operand captured at start |
| rec_en | input | 1 | Condition-record enable |
| ffirst_en | input | 1 | Fail-first mode enable |
| bit_sel | input | 2 | Tested bit selector |
| inv | input | 1 | Invert the test |
| incl | input | 1 | Inclusive truncation |
| wide_sel | input | 1 | Destination is a single-bit selector; forces equal-bit test |
| elem_idx | output | LW | Element read index |
| elem_data | input | DW | Signed element at `elem_idx` |
| cf_we | output | 1 | Condition-field write enable |
| cf_idx | output | LW | Condition-field index for read and write |
| cf_wdata | output | 4 | Condition-field write data |
| cf_rdata | input | 4 | Current condition field at `cf_idx` |
| vl_out | output | LW | Final vector length |
| done | output | 1 | Loop-finished pulse |

## Verification
The normal compare write and the truncation decision fall in the same cycle. On an exclusive hit, one cycle must both suppress the new field in favour of the restored prior value and fix the shortened length, so the next cycle's `done` carries a value that depends on that same step. This is provoked by pre-filling the bench's condition store with non-zero values and placing hits on the first, a middle and the last element. A scoreboard judges the exact write sequence and the length reported with `done`. A start pulse landing on a busy loop is also driven, and it must leave both untouched.

// File: rtl/vcmp_ff_pkg.sv
package vcmp_ff_pkg;

  localparam int CF_W = 4;

  localparam logic [CF_W-1:0] CF_LT = 4'b1000;
  localparam logic [CF_W-1:0] CF_GT = 4'b0100;
  localparam logic [CF_W-1:0] CF_EQ = 4'b0010;

  localparam logic [1:0] SEL_EQ = 2'd2;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic       rec_en;
    logic       ffirst_en;
    logic [1:0] bit_sel;
    logic       inv;
    logic       incl;
    logic       wide_sel;
  } ff_cfg_t;

endpackage

// File: rtl/vcmp_ff_cmp.sv
module vcmp_ff_cmp
  import vcmp_ff_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] elem,
  input  logic signed [DW-1:0] scal,
  output logic [CF_W-1:0]      field
);

  logic is_lt;
  logic is_gt;

  always_comb begin
    is_lt = (elem < scal);
    is_gt = (elem > scal);
    if (is_lt) begin
      field = CF_LT;
    end else if (is_gt) begin
      field = CF_GT;
    end else begin
      field = CF_EQ;
    end
  end

endmodule

// File: rtl/vcmp_ff_test.sv
module vcmp_ff_test
  import vcmp_ff_pkg::*;
(
  input  logic [CF_W-1:0] field,
  input  ff_cfg_t         cfg,
  output logic            hit
);

  logic [1:0] sel_eff;
  logic       raw_bit;
  logic       armed;

  always_comb begin
    sel_eff = cfg.wide_sel ? SEL_EQ : cfg.bit_sel;
    case (sel_eff)
      2'd0:    raw_bit = field[3];
      2'd1:    raw_bit = field[2];
      2'd2:    raw_bit = field[1];
      default: raw_bit = field[0];
    endcase
    armed = cfg.rec_en & cfg.ffirst_en;
    hit   = armed & (raw_bit ^ cfg.inv);
  end

endmodule

// File: rtl/vcmp_ff_ctrl.sv
module vcmp_ff_ctrl
  import vcmp_ff_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] vlen,
  input  logic          hit,
  input  logic          incl,
  output logic          running,
  output logic          accept,
  output logic [LW-1:0] step,
  output logic [LW-1:0] vl_out,
  output logic          done
);

  localparam logic [LW-1:0] ONE = LW'(1);

  seq_state_e    st_q, st_d;
  logic [LW-1:0] step_q, step_d;
  logic [LW-1:0] len_q, len_d;
  logic [LW-1:0] vl_q, vl_d;
  logic          done_q, done_d;
  logic          last_step;

  always_comb begin
    st_d      = st_q;
    step_d    = step_q;
    len_d     = len_q;
    vl_d      = vl_q;
    done_d    = 1'b0;
    accept    = 1'b0;
    last_step = (step_q == (len_q - ONE));
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          len_d  = vlen;
          step_d = '0;
          if (vlen == '0) begin
            vl_d   = '0;
            done_d = 1'b1;
          end else begin
            st_d = ST_RUN;
          end
        end
      end
      default: begin
        if (hit) begin
          vl_d   = incl ? (step_q + ONE) : step_q;
          done_d = 1'b1;
          st_d   = ST_IDLE;
          step_d = '0;
        end else if (last_step) begin
          vl_d   = len_q;
          done_d = 1'b1;
          st_d   = ST_IDLE;
          step_d = '0;
        end else begin
          step_d = step_q + ONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      len_q  <= '0;
      vl_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      len_q  <= len_d;
      vl_q   <= vl_d;
      done_q <= done_d;
    end
  end

  assign running = (st_q == ST_RUN);
  assign step    = step_q;
  assign vl_out  = vl_q;
  assign done    = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9

  AST_VL_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vl_q) |-> done_q); // R9

  AST_VL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (vl_q <= len_q)); // R6

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (step_q < len_q)); // R2

  AST_EXCL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && hit && !incl) |=> (done_q && vl_q == $past(step_q))); // R7

endmodule

// File: rtl/vcmp_ff_seq.sv
module vcmp_ff_seq
  import vcmp_ff_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LW-1:0]        vlen,
  input  logic signed [DW-1:0] scalar,
  input  logic                 rec_en,
  input  logic                 ffirst_en,
  input  logic [1:0]           bit_sel,
  input  logic                 inv,
  input  logic                 incl,
  input  logic                 wide_sel,
  output logic [LW-1:0]        elem_idx,
  input  logic signed [DW-1:0] elem_data,
  output logic                 cf_we,
  output logic [LW-1:0]        cf_idx,
  output logic [3:0]           cf_wdata,
  input  logic [3:0]           cf_rdata,
  output logic [LW-1:0]        vl_out,
  output logic                 done
);

  ff_cfg_t               cfg_q, cfg_d;
  logic signed [DW-1:0]  scal_q, scal_d;
  logic                  running;
  logic                  accept;
  logic [LW-1:0]         step;
  logic [CF_W-1:0]       field;
  logic                  test_hit;
  logic                  hit;
  logic                  restore;

  // capture operands and configuration on an accepted start
  always_comb begin
    cfg_d  = cfg_q;
    scal_d = scal_q;
    if (accept) begin
      cfg_d  = '{rec_en: rec_en, ffirst_en: ffirst_en, bit_sel: bit_sel,
                 inv: inv, incl: incl, wide_sel: wide_sel};
      scal_d = scalar;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      scal_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      scal_q <= scal_d;
    end
  end

  vcmp_ff_cmp #(.DW(DW)) u_cmp (
    .elem  (elem_data),
    .scal  (scal_q),
    .field (field)
  );

  vcmp_ff_test u_test (
    .field (field),
    .cfg   (cfg_q),
    .hit   (test_hit)
  );

  assign hit = running & test_hit;

  vcmp_ff_ctrl #(.LW(LW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .vlen    (vlen),
    .hit     (hit),
    .incl    (cfg_q.incl),
    .running (running),
    .accept  (accept),
    .step    (step),
    .vl_out  (vl_out),
    .done    (done)
  );

  always_comb begin
    restore  = hit & ~cfg_q.incl;
    elem_idx = step;
    cf_idx   = step;
    cf_we    = running;
    cf_wdata = restore ? cf_rdata : field;
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !cf_we); // R8

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_we && $past(cf_we)) |-> (cf_idx == $past(cf_idx) + LW'(1))); // R2

  AST_FIELD_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_we && !restore) |-> ($onehot0(cf_wdata) && cf_wdata[0] == 1'b0
                              && cf_wdata != 4'b0000)); // R1

  AST_NO_HIT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(cfg_q.rec_en && cfg_q.ffirst_en)) |-> !hit); // R3

endmodule

// File: tb/vcmp_ff_seq_tb.sv
module vcmp_ff_seq_tb;

  localparam int DW = 16;
  localparam int LW = 4;
  localparam int NE = 1 << LW;

  logic                 clk;
  logic                 rst_n;
  logic                 start;
  logic [LW-1:0]        vlen;
  logic signed [DW-1:0] scalar;
  logic                 rec_en, ffirst_en, inv, incl, wide_sel;
  logic [1:0]           bit_sel;
  logic [LW-1:0]        elem_idx;
  logic signed [DW-1:0] elem_data;
  logic                 cf_we;
  logic [LW-1:0]        cf_idx;
  logic [3:0]           cf_wdata;
  logic [3:0]           cf_rdata;
  logic [LW-1:0]        vl_out;
  logic                 done;

  logic signed [DW-1:0] elems  [NE];
  logic [3:0]           cf_mem [NE];

  int checks;
  int failures;
  int done_cnt;
  int cyc;

  logic [LW+3:0] exp_w [$];
  string         exp_wt [$];
  logic [LW-1:0] exp_v [$];
  string         exp_vt [$];

  vcmp_ff_seq #(.DW(DW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .scalar(scalar),
    .rec_en(rec_en), .ffirst_en(ffirst_en), .bit_sel(bit_sel), .inv(inv),
    .incl(incl), .wide_sel(wide_sel), .elem_idx(elem_idx),
    .elem_data(elem_data), .cf_we(cf_we), .cf_idx(cf_idx),
    .cf_wdata(cf_wdata), .cf_rdata(cf_rdata), .vl_out(vl_out), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign elem_data = elems[elem_idx];
  assign cf_rdata  = cf_mem[cf_idx];

  always @(posedge clk) begin
    if (cf_we) cf_mem[cf_idx] <= cf_wdata;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes and lengths
  logic prev_done;
  initial prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cf_we) begin
        if (exp_w.size() == 0) begin
          check(1'b0, "R2 unexpected write", int'({cf_idx, cf_wdata}), -1);
        end else begin
          logic [LW+3:0] e;
          string t;
          e = exp_w.pop_front();
          t = exp_wt.pop_front();
          check({cf_idx, cf_wdata} == e && elem_idx == cf_idx, t,
                int'({cf_idx, cf_wdata}), int'(e));
        end
      end
      if (done) begin
        check(prev_done == 1'b0, "R9 done width", 1, 0);
        check(exp_w.size() == 0, "R2 writes missing at done", exp_w.size(), 0);
        if (exp_v.size() == 0) begin
          check(1'b0, "R9 unexpected done", int'(vl_out), -1);
        end else begin
          logic [LW-1:0] v;
          string t;
          v = exp_v.pop_front();
          t = exp_vt.pop_front();
          check(vl_out == v, t, int'(vl_out), int'(v));
        end
        done_cnt++;
      end
      prev_done = done;
    end
  end

  // driver: builds expectations from the requirements, then starts the loop
  task automatic run_case(input string tag, input int n, input int sc,
                          input bit r, input bit f, input int sel, input bit iv,
                          input bit ic, input bit wd, input bit bump);
    int vl_e;
    int d0;
    int sel_e;
    vl_e  = n;
    sel_e = wd ? 2 : sel;
    for (int s = 0; s < n; s++) begin
      logic [3:0] fld;
      bit tb;
      if (elems[s] < DW'(sc))      fld = 4'b1000;
      else if (elems[s] > DW'(sc)) fld = 4'b0100;
      else                         fld = 4'b0010;
      tb = fld[3 - sel_e] ^ iv;
      if (r && f && tb) begin
        exp_w.push_back({LW'(s), ic ? fld : cf_mem[s]});
        exp_wt.push_back({tag, " hit write"});
        vl_e = ic ? s + 1 : s;
        break;
      end
      exp_w.push_back({LW'(s), fld});
      exp_wt.push_back({tag, " write"});
    end
    exp_v.push_back(LW'(vl_e));
    exp_vt.push_back({tag, " length"});
    d0 = done_cnt;
    @(posedge clk); #1;
    start = 1'b1; vlen = LW'(n); scalar = DW'(sc);
    rec_en = r; ffirst_en = f; bit_sel = 2'(sel); inv = iv; incl = ic; wide_sel = wd;
    @(posedge clk); #1;
    start = 1'b0;
    if (bump) begin
      @(posedge clk); #1;
      start = 1'b1; vlen = LW'(1); scalar = DW'(-7); rec_en = 1'b1; ffirst_en = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (done_cnt == d0) @(posedge clk);
    repeat (3) @(negedge clk);
    check(vl_out == LW'(vl_e), {tag, " R9 length held"}, int'(vl_out), vl_e);
  endtask

  task automatic set_vec(input int n, input int base);
    for (int i = 0; i < NE; i++) begin
      elems[i] = DW'(base + i);
      cf_mem[i] = 4'(i + 3);
    end
    if (n < 0) elems[0] = '0;
  endtask

  initial begin
    checks = 0; failures = 0; done_cnt = 0;
    start = 0; vlen = 0; scalar = 0; rec_en = 0; ffirst_en = 0;
    bit_sel = 0; inv = 0; incl = 0; wide_sel = 0;
    for (int i = 0; i < NE; i++) begin elems[i] = '0; cf_mem[i] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 0 && vl_out == 0 && cf_we == 0, "R10 in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 0 && vl_out == 0 && cf_we == 0, "R10 after reset", int'(vl_out), 0);

    // {1,2,3} vs 2, equal test, inclusive: fields 8,2 and length 2
    set_vec(0, 1);
    for (int i = 0; i < 3; i++) cf_mem[i] = 4'h0;
    run_case("R6 inclusive eq", 3, 2, 1, 1, 2, 0, 1, 0, 0);
    check(cf_mem[2] == 4'h0, "R6 element past hit untouched", int'(cf_mem[2]), 0);

    // same, exclusive, prior value 9 restored on element 1
    set_vec(0, 1);
    cf_mem[1] = 4'h9;
    run_case("R7 exclusive eq", 3, 2, 1, 1, 2, 0, 0, 0, 0);
    check(cf_mem[1] == 4'h9, "R7 field restored", int'(cf_mem[1]), 9);

    // record enable off: full length
    set_vec(0, 1);
    run_case("R3 record off", 3, 2, 0, 1, 2, 0, 0, 0, 0);
    // fail-first off: full length
    run_case("R3 ffirst off", 5, 3, 1, 0, 2, 0, 1, 0, 0);

    // inverted LT test: {-3,-1,4,0} vs 0 -> hit at 2, inclusive -> 3
    set_vec(0, 0);
    elems[0] = -16'sd3; elems[1] = -16'sd1; elems[2] = 16'sd4; elems[3] = 16'sd0;
    run_case("R4 inverted lt", 4, 0, 1, 1, 0, 1, 1, 0, 0);
    // GT selector, not inverted, exclusive: hit at 2
    run_case("R4 gt select", 4, 0, 1, 1, 1, 0, 0, 0, 0);

    // wide flag overrides LT selector: {5,7,7,1} vs 7 -> hit at 1, exclusive
    set_vec(0, 0);
    elems[0] = 16'sd5; elems[1] = 16'sd7; elems[2] = 16'sd7; elems[3] = 16'sd1;
    run_case("R5 wide forces eq", 4, 7, 1, 1, 0, 0, 0, 1, 0);

    // zero length
    run_case("R8 zero length", 0, 7, 1, 1, 2, 0, 1, 0, 0);

    // start while busy is ignored
    set_vec(0, 10);
    run_case("R9 busy start ignored", 6, 12, 0, 0, 2, 0, 0, 0, 1);

    // hit on first element, exclusive -> length 0
    set_vec(0, 4);
    run_case("R7 first element hit", 5, 4, 1, 1, 2, 0, 0, 0, 0);

    // hit on last element of full-size vector, inclusive
    set_vec(0, 0);
    run_case("R6 last element hit", NE - 1, NE - 2, 1, 1, 2, 0, 1, 0, 0);

    // signed extremes, no truncation
    elems[0] = -16'sd32768; elems[1] = 16'sd32767; elems[2] = 16'sd0;
    run_case("R1 signed extremes", 3, 0, 0, 0, 0, 0, 0, 0, 0);
    run_case("R1 negative scalar", 3, -32768, 0, 0, 0, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule